// File: doc/BRIEF.md
# Descriptor Ring Fetch Sequencer

This block steps one DMA channel through a circular ring of fixed-size descriptors held in memory. Software sets up the ring's base address, its length and a tail pointer through a small write port, then sets the start bit. The engine holds a current-descriptor pointer and requests one descriptor at a time over a valid/ready fetch port. The pointer moves to the next slot only once the fetch response has returned and the consumer has signalled that it is done with the descriptor.

Ownership comes from the tail pointer alone. Descriptors from the current pointer up to the slot just before the tail belong to the engine. When the current pointer reaches the tail, the engine suspends. A later tail write that puts the tail ahead of the current pointer restarts it. After the last slot the pointer wraps back to the base address. The current pointer and a suspended flag are visible at the ports.

Top module: `desc_ring_engine`

## Requirements
- R1: After reset, `fetch_valid` is 0, `suspended` is 0 and `cur_desc_addr` is 0.
- R2: Writes with `reg_sel` = 1 set the base register. Writing `reg_sel` = 0 with bit 0 set while stopped starts the engine, and `cur_desc_addr` loads the base address at that point. A base write while the engine runs does not change the current pointer or the wrap target until the next start.
- R3: While running and not waiting on a fetch, `fetch_valid` is high exactly when the current pointer differs from the tail. `fetch_addr` then equals `cur_desc_addr`, and both stay steady until `fetch_ready` is seen.
- R4: At most one fetch is outstanding. After a grant, `fetch_valid` stays low until both `resp_valid` and `proc_done` have been seen, in either order or in the same cycle.
- R5: When the second of `resp_valid` and `proc_done` arrives, the current pointer advances by DESC_BYTES on that clock edge. It does not move before then.
- R6: Writes with `reg_sel` = 2 hold the descriptor count minus one. When the pointer advances from base + len*DESC_BYTES, it goes back to base.
- R7: `suspended` is high while the engine runs, has no fetch outstanding, and the current pointer equals the tail. A tail write (`reg_sel` = 3) to a different slot clears it on the write's clock edge, and fetching resumes.
- R8: Writing `reg_sel` = 0 with bit 0 clear stops the engine. `fetch_valid` and `suspended` go low and any outstanding fetch is abandoned, so late responses do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 base, 2 length, 3 tail |
| reg_wdata | input | ADDR_W | Register write data |
| fetch_valid | output | 1 | Descriptor fetch request |
| fetch_ready | input | 1 | Fetch request grant |
| fetch_addr | output | ADDR_W | Address of the descriptor requested |
| resp_valid | input | 1 | Fetch response returned |
| proc_done | input | 1 | Consumer finished with the fetched descriptor |
| cur_desc_addr | output | ADDR_W | Current descriptor pointer |
| suspended | output | 1 | Engine running but idle at the tail |

## Verification
Ring sizes of two to five descriptors are swept. Tail advances vary from one slot up to one less than the ring size. Together these cover every wrap position and show that the wrap is computed from the length register rather than from a fixed size.

Each fetch is completed with the response first, with done first, or with both in the same cycle. The ordering cases show that the pointer waits for both completions and never for only one.

Separate sequences test three things:
- a base write while the engine runs, followed by a wrap, to show that the old base stays in use;
- a stop with a fetch outstanding, followed by late completions, to show that they are ignored;
- a tail write that ends a suspension.

// File: rtl/desc_ring_engine.sv
module desc_ring_engine #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 10,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              resp_valid,
  input  logic              proc_done,
  output logic [ADDR_W-1:0] cur_desc_addr,
  output logic              suspended
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  logic              run, busy, got_resp, got_done;
  logic [ADDR_W-1:0] base_q, act_base, tail_q, cur_q;
  logic [LEN_W-1:0]  len_q, act_len;

  wire wr_ctrl  = reg_we && (reg_sel == 2'd0);
  wire start    = wr_ctrl && reg_wdata[0] && !run;
  wire stop     = wr_ctrl && !reg_wdata[0];
  wire resp_now = got_resp | resp_valid;
  wire done_now = got_done | proc_done;
  wire advance  = run && busy && resp_now && done_now;
  wire grant    = fetch_valid && fetch_ready;

  wire [ADDR_W-1:0] last_addr = act_base + ADDR_W'(act_len) * STEP;
  wire [ADDR_W-1:0] next_cur  = (cur_q == last_addr) ? act_base : cur_q + STEP;

  assign fetch_valid   = run && !busy && (cur_q != tail_q);
  assign suspended     = run && !busy && (cur_q == tail_q);
  assign fetch_addr    = cur_q;
  assign cur_desc_addr = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0; len_q <= '0; tail_q <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        2'd1: base_q <= reg_wdata;
        2'd2: len_q  <= reg_wdata[LEN_W-1:0];
        2'd3: tail_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; busy <= 1'b0; got_resp <= 1'b0; got_done <= 1'b0;
      cur_q <= '0; act_base <= '0; act_len <= '0;
    end else if (start) begin
      run <= 1'b1; busy <= 1'b0; got_resp <= 1'b0; got_done <= 1'b0;
      cur_q <= base_q; act_base <= base_q; act_len <= len_q;
    end else if (stop) begin
      run <= 1'b0; busy <= 1'b0; got_resp <= 1'b0; got_done <= 1'b0;
    end else if (run) begin
      if (grant) begin
        busy <= 1'b1;
      end else if (advance) begin
        busy <= 1'b0; got_resp <= 1'b0; got_done <= 1'b0;
        cur_q <= next_cur;
      end else if (busy) begin
        got_resp <= resp_now;
        got_done <= done_now;
      end
    end
  end

  // R4: no request while a fetch is outstanding
  p_single_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fetch_valid);
  // R3: the engine never requests the slot the tail points at
  p_no_fetch_at_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (fetch_addr != tail_q));
  // R3: a request stays put until granted
  p_hold_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !reg_we) |=> (fetch_valid && $stable(fetch_addr)));
  // R6: advancing from the last slot returns to the base
  p_wrap_to_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !reg_we && cur_q == last_addr) |=> (cur_q == act_base));
  // R5: the pointer only moves by one descriptor on completion
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !advance && !start) |=> $stable(cur_q));
  // R8: a stopped engine is quiet
  p_stopped_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!fetch_valid && !suspended));
  // R7: suspended and requesting never coincide
  p_susp_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(suspended && fetch_valid));
endmodule

// File: tb/desc_ring_engine_bench.sv
module desc_ring_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int LW = 4;
  localparam int DB = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_sel = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic          fetch_ready = 1'b0, resp_valid = 1'b0, proc_done = 1'b0;
  logic          fetch_valid, suspended;
  logic [AW-1:0] fetch_addr, cur_desc_addr;

  int checks = 0;
  int errors = 0;

  desc_ring_engine #(.ADDR_W(AW), .LEN_W(LW), .DESC_BYTES(DB)) u_desc_ring_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .resp_valid(resp_valid), .proc_done(proc_done),
    .cur_desc_addr(cur_desc_addr), .suspended(suspended));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] data);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic serve(input logic [AW-1:0] exp_addr, input int mode, input logic [AW-1:0] nxt);
    chk("R3 request", {31'd0, fetch_valid}, 32'd1);
    chk("R3 address", {16'd0, fetch_addr}, {16'd0, exp_addr});
    if (mode == 0) begin
      @(negedge clk);
      chk("R3 hold", {15'd0, fetch_valid, fetch_addr}, {15'd0, 1'b1, exp_addr});
    end
    fetch_ready = 1'b1; @(negedge clk); fetch_ready = 1'b0;
    chk("R4 no second request", {31'd0, fetch_valid}, 32'd0);
    if (mode == 2) begin
      resp_valid = 1'b1; proc_done = 1'b1; @(negedge clk);
      resp_valid = 1'b0; proc_done = 1'b0;
    end else begin
      if (mode == 0) resp_valid = 1'b1; else proc_done = 1'b1;
      @(negedge clk);
      resp_valid = 1'b0; proc_done = 1'b0;
      chk("R4 still waiting", {31'd0, fetch_valid}, 32'd0);
      chk("R5 no early advance", {16'd0, cur_desc_addr}, {16'd0, exp_addr});
      if (mode == 0) proc_done = 1'b1; else resp_valid = 1'b1;
      @(negedge clk);
      resp_valid = 1'b0; proc_done = 1'b0;
    end
    chk("R5/R6 advance", {16'd0, cur_desc_addr}, {16'd0, nxt});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] base, a_old, b_new;
    int idx, tidx, batch;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 fetch_valid", {31'd0, fetch_valid}, 32'd0);
    chk("R1 suspended", {31'd0, suspended}, 32'd0);
    chk("R1 cur", {16'd0, cur_desc_addr}, 32'd0);

    for (int n = 2; n <= 5; n++) begin
      base = AW'(16'h0100 + n * 16'h0200);
      wr(2'd1, base); wr(2'd2, AW'(n - 1)); wr(2'd3, base); wr(2'd0, 16'h1);
      chk("R2 start loads base", {16'd0, cur_desc_addr}, {16'd0, base});
      chk("R7 empty ring suspends", {31'd0, suspended}, 32'd1);
      chk("R3 no request when empty", {31'd0, fetch_valid}, 32'd0);
      idx = 0;
      for (int r = 0; r < 2 * n + 1; r++) begin
        batch = (r % (n - 1)) + 1;
        tidx = (idx + batch) % n;
        wr(2'd3, AW'(base + tidx * DB));
        chk("R7 tail write resumes", {31'd0, suspended}, 32'd0);
        for (int j = 0; j < batch; j++) begin
          serve(AW'(base + idx * DB), (r + j) % 3, AW'(base + ((idx + 1) % n) * DB));
          idx = (idx + 1) % n;
        end
        chk("R7 suspended at tail", {31'd0, suspended}, 32'd1);
        chk("R7 cur equals tail", {16'd0, cur_desc_addr}, {16'd0, AW'(base + tidx * DB)});
      end
      wr(2'd0, 16'h0);
      chk("R8 stop clears suspended", {31'd0, suspended}, 32'd0);
    end

    a_old = 16'h0100; b_new = 16'h0800;
    wr(2'd1, a_old); wr(2'd2, 16'd2); wr(2'd3, a_old); wr(2'd0, 16'h1);
    wr(2'd3, AW'(a_old + 2 * DB));
    serve(a_old, 2, AW'(a_old + DB));
    wr(2'd1, b_new);
    chk("R2 base write while running ignored", {16'd0, cur_desc_addr}, {16'd0, AW'(a_old + DB)});
    wr(2'd3, a_old);
    serve(AW'(a_old + DB), 1, AW'(a_old + 2 * DB));
    serve(AW'(a_old + 2 * DB), 0, a_old);
    chk("R6 wrap uses old base", {31'd0, suspended}, 32'd1);
    wr(2'd0, 16'h0);
    chk("R8 stop quiets request", {31'd0, fetch_valid}, 32'd0);
    chk("R8 stop keeps pointer", {16'd0, cur_desc_addr}, {16'd0, a_old});
    wr(2'd0, 16'h1);
    chk("R2 restart loads new base", {16'd0, cur_desc_addr}, {16'd0, b_new});
    chk("R3 request at new base", {15'd0, fetch_valid, fetch_addr}, {15'd0, 1'b1, b_new});
    fetch_ready = 1'b1; @(negedge clk); fetch_ready = 1'b0;
    wr(2'd0, 16'h0);
    chk("R8 stop with fetch outstanding", {30'd0, fetch_valid, suspended}, 32'd0);
    resp_valid = 1'b1; proc_done = 1'b1; @(negedge clk);
    resp_valid = 1'b0; proc_done = 1'b0;
    chk("R8 late completion ignored", {16'd0, cur_desc_addr}, {16'd0, b_new});
    wr(2'd0, 16'h1);
    chk("R8 abandoned fetch reissued", {15'd0, fetch_valid, fetch_addr}, {15'd0, 1'b1, b_new});
    wr(2'd3, b_new);
    chk("R7 tail at cur suspends", {31'd0, suspended}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule